// File: doc/BRIEF.md
# Message-Signalled Interrupt Address Composer

This block turns interrupt events into single memory-write requests. Each interrupt source has a 32-bit routing word that names a destination hart, a guest context and a message identifier. A pair of configuration words sets a base page and four shift/width fields. The block combines them into a 64-bit write address, in which a group index, a hart index and a guest index are interleaved into the page number. The identifier is sent as the 32-bit write data.

The block holds a pending flag for every source. A source is sent when the domain enable is set and the source is both enabled and pending. Its pending flag is cleared on the clock edge that loads the request into the output register. Software can also write a generate word, which queues one message built from that word's hart index and identifier with guest index zero. A queued generate message goes ahead of source messages. Waiting sources go out one per accepted request, lowest index first. The request uses a valid/ready handshake and holds steady until it is accepted.

The configuration words can be frozen with a lock bit in the high word. Only a reset clears the lock. A parameter selects the machine-level variant, which always forces the guest index to zero.

Top module: `msi_msg_composer`

## Requirements
- R1: After reset, `msg_valid`, every pending flag, both configuration words and the stored generate word are all zero.
- R2: A write to the high configuration word keeps only its defined fields: bit 31 lock, 28:24 high shift, 22:20 low shift, 18:16 high width, 15:12 low width, 11:0 upper base page. Every other bit reads back as zero.
- R3: While bit 31 of the high configuration word is set, writes to either configuration word leave both words unchanged.
- R4: The routing word holds the hart index in bits 31:18, the guest index in 17:12 and the identifier in 10:0. The group index is the hart index shifted right by the low width, masked to the high width, and placed at bit (high shift + 12) of the page number. The hart index, masked to the low width, is placed at bit (low shift). The guest index, masked to (low shift) bits, is placed at bit 0. The low base word is ORed in at bit 0 and the upper base bits at bit 32. The address is the page number shifted left by 12.
- R5: `msg_data` is the 11-bit identifier, zero-extended to 32 bits.
- R6: A source is sent only while `dom_en`, its enable bit and its pending flag are all 1. Otherwise it stays pending and no request is raised for it.
- R7: A source's pending flag is cleared on the edge that loads its request, unless a new set pulse arrives on that same edge.
- R8: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid`, `msg_addr` and `msg_data` hold their values.
- R9: When several sources are ready, one request is issued per accepted request, in ascending source index.
- R10: A write to the generate word queues a message from its bits 31:18 (hart) and 10:0 (identifier) with guest index 0. The stored copy reads back with bits 17:12 cleared.
- R11: A queued generate message is issued before any ready source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dom_en | input | 1 | Domain delivery enable |
| src_en | input | NSRC | Per-source enable bits |
| src_pend_set | input | NSRC | Per-source pulse that sets the pending flag |
| src_target | input | NSRC*32 | Routing words, source i in bits 32*i+31:32*i |
| pend_o | output | NSRC | Pending flags |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_hi | input | 1 | 1 selects the high word, 0 the low word |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_lo_o | output | 32 | Low configuration word (base page bits 31:0) |
| cfg_hi_o | output | 32 | High configuration word |
| gen_wr_en | input | 1 | Generate-word write strobe |
| gen_wr_data | input | 32 | Generate-word write data |
| gen_o | output | 32 | Stored generate word |
| msg_valid | output | 1 | Write request valid |
| msg_ready | input | 1 | Write request accepted |
| msg_addr | output | 64 | Write address |
| msg_data | output | 32 | Write data |

## Verification
The vector table covers several field layouts: a guest index wider than the low shift allows, a low width of zero, a large low width that moves no group bits, and a wide group placed at a large high shift. A design that masks with the wrong field, or shifts the group by the high shift without adding 12, produces a different address. The directed tests cover the following cases:
- A source is kept pending while the domain is disabled, which catches a design that ignores `dom_en`.
- A request is held against a stalled `msg_ready`, which catches a design that drops or changes a request that has not been accepted.
- Three sources are set at once, which catches an arbiter that sends them out of ascending order.
- A generate word is written with a full guest field, which catches a design that leaks the guest index into the address.
- A generate write and a source event arrive together, which catches a design that lets the source go first.
- Writes are made after the lock bit is set, which catches a design whose lock does not freeze both words.

// File: rtl/msi_comp_pkg.sv
package msi_comp_pkg;

   // Fields of the high configuration word. The positions are fixed because
   // software composes this word directly.
   typedef struct packed {
      logic        lock;
      logic [1:0]  rsv_a;
      logic [4:0]  hi_shift;
      logic        rsv_b;
      logic [2:0]  lo_shift;
      logic        rsv_c;
      logic [2:0]  hi_width;
      logic [3:0]  lo_width;
      logic [11:0] base_hi;
   } cfg_hi_t;

   // Fields of a routing word; the generate word uses the same layout.
   typedef struct packed {
      logic [13:0] hart;
      logic [5:0]  guest;
      logic        rsv;
      logic [10:0] eiid;
   } route_t;

   localparam logic [31:0] CFG_HI_KEEP = 32'h9F77_FFFF;
   localparam logic [31:0] GUEST_CLR   = 32'hFFFC_0FFF;
   localparam int unsigned PAGE_SHIFT  = 12;

endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
   import msi_comp_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        wr_hi,
   input  logic [31:0] wr_data,
   output logic [31:0] lo_q,
   output logic [31:0] hi_q
);

   logic locked;
   assign locked = hi_q[31];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (wr_en && !locked) begin
         if (wr_hi) hi_q <= wr_data & CFG_HI_KEEP;
         else       lo_q <= wr_data;
      end
   end

   assert_lock_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hi_q[31] |=> ($stable(lo_q) && $stable(hi_q)));

   assert_hi_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_hi && !hi_q[31]) |=> ((hi_q & ~CFG_HI_KEEP) == 32'd0));

endmodule

// File: rtl/msi_src_picker.sv
module msi_src_picker #(
   parameter int unsigned NSRC  = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dom_en,
   input  logic [NSRC-1:0]  en,
   input  logic [NSRC-1:0]  pend_set,
   input  logic             take,
   output logic [NSRC-1:0]  pend_q,
   output logic             pick_vld,
   output logic [IDX_W-1:0] pick_idx
);

   logic [NSRC-1:0] ready;
   logic [NSRC-1:0] grant;

   assign ready = pend_q & en & {NSRC{dom_en}};

   // The lowest ready index wins.
   always_comb begin
      pick_vld = 1'b0;
      pick_idx = '0;
      grant    = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (ready[i] && !pick_vld) begin
            pick_vld = 1'b1;
            pick_idx = IDX_W'(i);
            grant[i] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~(grant & {NSRC{take}})) | pend_set;
   end

   assert_grant_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant & ~(pend_q & en)) == '0) && (dom_en || (grant == '0)));

   assert_grant_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   for (genvar g = 0; g < NSRC; g++) begin : g_clr_chk
      assert_pend_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (take && grant[g] && !pend_set[g]) |=> !pend_q[g]);
   end

endmodule

// File: rtl/msi_addr_calc.sv
module msi_addr_calc
   import msi_comp_pkg::*;
#(
   parameter bit MACHINE_LEVEL = 1'b0
) (
   input  logic [31:0] base_lo,
   input  logic [11:0] base_hi,
   input  logic [4:0]  hi_shift,
   input  logic [2:0]  lo_shift,
   input  logic [2:0]  hi_width,
   input  logic [3:0]  lo_width,
   input  logic [13:0] hart,
   input  logic [5:0]  guest,
   input  logic [10:0] eiid,
   output logic [63:0] addr,
   output logic [31:0] data
);

   logic [63:0] hart_w;
   logic [63:0] group_w;
   logic [63:0] group_m;
   logic [63:0] hart_m;
   logic [63:0] guest_w;
   logic [6:0]  group_pos;
   logic [63:0] ppn;

   assign hart_w    = {50'd0, hart};
   assign group_w   = hart_w >> lo_width;
   assign group_m   = group_w & ((64'd1 << hi_width) - 64'd1);
   assign hart_m    = hart_w & ((64'd1 << lo_width) - 64'd1);
   assign group_pos = {2'b00, hi_shift} + 7'(PAGE_SHIFT);

   if (MACHINE_LEVEL) begin : g_machine
      logic unused_guest;
      assign unused_guest = ^guest;
      assign guest_w = 64'd0;
   end else begin : g_super
      assign guest_w = {58'd0, guest} & ((64'd1 << lo_shift) - 64'd1);
   end

   assign ppn = {32'd0, base_lo}
              | {20'd0, base_hi, 32'd0}
              | (group_m << group_pos)
              | (hart_m << lo_shift)
              | guest_w;

   assign addr = ppn << PAGE_SHIFT;
   assign data = {21'd0, eiid};

endmodule

// File: rtl/msi_msg_composer.sv
module msi_msg_composer
   import msi_comp_pkg::*;
#(
   parameter int unsigned NSRC          = 8,
   parameter bit          MACHINE_LEVEL = 1'b0,
   localparam int unsigned IDX_W        = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dom_en,
   input  logic [NSRC-1:0]   src_en,
   input  logic [NSRC-1:0]   src_pend_set,
   input  logic [NSRC*32-1:0] src_target,
   output logic [NSRC-1:0]   pend_o,
   input  logic              cfg_wr_en,
   input  logic              cfg_wr_hi,
   input  logic [31:0]       cfg_wr_data,
   output logic [31:0]       cfg_lo_o,
   output logic [31:0]       cfg_hi_o,
   input  logic              gen_wr_en,
   input  logic [31:0]       gen_wr_data,
   output logic [31:0]       gen_o,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [63:0]       msg_addr,
   output logic [31:0]       msg_data
);

   if (NSRC < 1 || NSRC > 1023) begin : g_bad_nsrc
      $error("msi_msg_composer: NSRC out of range");
   end

   // Configuration words with lock.
   msi_cfg_regs u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_hi   (cfg_wr_hi),
      .wr_data (cfg_wr_data),
      .lo_q    (cfg_lo_o),
      .hi_q    (cfg_hi_o)
   );

   cfg_hi_t hi_f;
   assign hi_f = cfg_hi_t'(cfg_hi_o);

   // Generate word: queued until the output register is free.
   logic gen_req_q;
   logic can_load;
   logic load_gen;
   logic load_src;
   logic pick_vld;
   logic [IDX_W-1:0] pick_idx;

   assign can_load = !msg_valid || msg_ready;
   assign load_gen = can_load && gen_req_q;
   assign load_src = can_load && !gen_req_q && pick_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_req_q <= 1'b0;
         gen_o     <= '0;
      end else if (gen_wr_en) begin
         gen_req_q <= 1'b1;
         gen_o     <= gen_wr_data & GUEST_CLR;
      end else if (load_gen) begin
         gen_req_q <= 1'b0;
      end
   end

   // Pending flags and ascending-order selection.
   msi_src_picker #(
      .NSRC  (NSRC),
      .IDX_W (IDX_W)
   ) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .dom_en   (dom_en),
      .en       (src_en),
      .pend_set (src_pend_set),
      .take     (load_src),
      .pend_q   (pend_o),
      .pick_vld (pick_vld),
      .pick_idx (pick_idx)
   );

   // Field selection: the generate word or the chosen routing word.
   route_t src_r;
   route_t gen_r;
   logic [13:0] sel_hart;
   logic [5:0]  sel_guest;
   logic [10:0] sel_eiid;

   assign src_r = route_t'(src_target[pick_idx*32 +: 32]);
   assign gen_r = route_t'(gen_o);

   always_comb begin
      if (gen_req_q) begin
         sel_hart  = gen_r.hart;
         sel_guest = 6'd0;
         sel_eiid  = gen_r.eiid;
      end else begin
         sel_hart  = src_r.hart;
         sel_guest = src_r.guest;
         sel_eiid  = src_r.eiid;
      end
   end

   logic unused_bits;
   assign unused_bits = ^{hi_f.lock, hi_f.rsv_a, hi_f.rsv_b, hi_f.rsv_c,
                          src_r.rsv, gen_r.guest, gen_r.rsv};

   logic [63:0] next_addr;
   logic [31:0] next_data;

   msi_addr_calc #(
      .MACHINE_LEVEL (MACHINE_LEVEL)
   ) u_calc (
      .base_lo  (cfg_lo_o),
      .base_hi  (hi_f.base_hi),
      .hi_shift (hi_f.hi_shift),
      .lo_shift (hi_f.lo_shift),
      .hi_width (hi_f.hi_width),
      .lo_width (hi_f.lo_width),
      .hart     (sel_hart),
      .guest    (sel_guest),
      .eiid     (sel_eiid),
      .addr     (next_addr),
      .data     (next_data)
   );

   // Output request register.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid <= 1'b0;
         msg_addr  <= '0;
         msg_data  <= '0;
      end else if (can_load) begin
         msg_valid <= load_gen || load_src;
         if (load_gen || load_src) begin
            msg_addr <= next_addr;
            msg_data <= next_data;
         end
      end
   end

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=>
         (msg_valid && $stable(msg_addr) && $stable(msg_data)));

   assert_gen_guest_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      gen_wr_en |=> (gen_o[17:12] == 6'd0));

   assert_gen_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_req_q && can_load && !gen_wr_en) |=> !gen_req_q);

endmodule

// File: tb/msi_msg_composer_bench.sv
module msi_msg_composer_bench;

   localparam int  CLK_PERIOD = 10;
   localparam int  NSRC       = 8;
   localparam int  NVEC       = 5;

   localparam logic [31:0] V_HI  [0:NVEC-1] = '{32'h0000_0000, 32'h0431_2001,
      32'h0010_0000, 32'h1F77_FFFF, 32'h1403_4000};
   localparam logic [31:0] V_LO  [0:NVEC-1] = '{32'h0008_0000, 32'h0010_0000,
      32'h0000_0000, 32'h0000_0000, 32'h0000_0000};
   localparam logic [31:0] V_TGT [0:NVEC-1] = '{32'h0000_0005, 32'h001C_57FF,
      32'hFFFC_7123, 32'hFFFC_0001, 32'h0168_3040};
   localparam logic [63:0] V_ADR [0:NVEC-1] = '{64'h0000_0000_8000_0000,
      64'h0000_1001_1001_D000, 64'h0000_0000_0000_1000,
      64'h00FF_F001_FFF8_0000, 64'h0000_5000_0000_A000};
   localparam logic [31:0] V_DAT [0:NVEC-1] = '{32'h5, 32'h7FF, 32'h123, 32'h1, 32'h40};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dom_en = 1'b0;
   logic [NSRC-1:0] src_en = '0;
   logic [NSRC-1:0] src_pend_set = '0;
   logic [NSRC*32-1:0] src_target = '0;
   logic [NSRC-1:0] pend_o;
   logic cfg_wr_en = 1'b0;
   logic cfg_wr_hi = 1'b0;
   logic [31:0] cfg_wr_data = '0;
   logic [31:0] cfg_lo_o, cfg_hi_o;
   logic gen_wr_en = 1'b0;
   logic [31:0] gen_wr_data = '0;
   logic [31:0] gen_o;
   logic msg_valid;
   logic msg_ready = 1'b0;
   logic [63:0] msg_addr;
   logic [31:0] msg_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   msi_msg_composer #(.NSRC(NSRC)) u_msi_msg_composer (
      .clk, .rst_n, .dom_en, .src_en, .src_pend_set, .src_target, .pend_o,
      .cfg_wr_en, .cfg_wr_hi, .cfg_wr_data, .cfg_lo_o, .cfg_hi_o,
      .gen_wr_en, .gen_wr_data, .gen_o,
      .msg_valid, .msg_ready, .msg_addr, .msg_data
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic hi, input logic [31:0] d);
      cfg_wr_en = 1'b1; cfg_wr_hi = hi; cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic pulse_pend(input logic [NSRC-1:0] m);
      src_pend_set = m;
      @(negedge clk);
      src_pend_set = '0;
   endtask

   task automatic wait_msg(output bit seen);
      seen = 1'b0;
      for (int k = 0; k < 16; k++) begin
         if (msg_valid) begin seen = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   task automatic accept();
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      bit seen;
      logic [63:0] a_hold;
      logic [31:0] d_hold;
      logic [31:0] lo_before;

      repeat (2) @(negedge clk);
      // R1: reset state
      chk("R1 valid", msg_valid, 0);
      chk("R1 pending", pend_o, 0);
      chk("R1 cfg_lo", cfg_lo_o, 0);
      chk("R1 cfg_hi", cfg_hi_o, 0);
      chk("R1 gen", gen_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: only the defined high-word fields are kept
      cfg_write(1'b1, 32'h7FFF_FFFF);
      chk("R2 hi mask", cfg_hi_o, 32'h1F77_FFFF);

      // R4/R5: table of layouts through source 0
      dom_en = 1'b1;
      src_en[0] = 1'b1;
      for (int v = 0; v < NVEC; v++) begin
         cfg_write(1'b0, V_LO[v]);
         cfg_write(1'b1, V_HI[v]);
         src_target[31:0] = V_TGT[v];
         pulse_pend(8'h01);
         wait_msg(seen);
         chk("R4 seen", seen, 1);
         chk("R4 addr", msg_addr, V_ADR[v]);
         chk("R5 data", msg_data, V_DAT[v]);
         accept();
      end

      // R6/R7: held while the domain is off, then sent and cleared
      dom_en = 1'b0;
      pulse_pend(8'h01);
      repeat (5) @(negedge clk);
      chk("R6 no msg while domain off", msg_valid, 0);
      chk("R6 still pending", pend_o[0], 1);
      src_en[0] = 1'b0;
      dom_en = 1'b1;
      repeat (5) @(negedge clk);
      chk("R6 no msg while source disabled", msg_valid, 0);
      src_en[0] = 1'b1;
      wait_msg(seen);
      chk("R6 sent once enabled", seen, 1);
      chk("R7 pending cleared on issue", pend_o[0], 0);
      accept();

      // R8/R9: three sources at once, stalled output
      cfg_write(1'b1, 32'h0);
      cfg_write(1'b0, 32'h0);
      src_target[1*32 +: 32] = 32'h0000_0011;
      src_target[2*32 +: 32] = 32'h0000_0022;
      src_target[5*32 +: 32] = 32'h0000_0055;
      src_en = 8'b0010_0110;
      pulse_pend(8'b0010_0110);
      wait_msg(seen);
      chk("R9 first is src1", msg_data, 32'h11);
      a_hold = msg_addr; d_hold = msg_data;
      repeat (3) @(negedge clk);
      chk("R8 valid held", msg_valid, 1);
      chk("R8 addr held", msg_addr, a_hold);
      chk("R8 data held", msg_data, d_hold);
      accept();
      chk("R9 second is src2", msg_data, 32'h22);
      accept();
      chk("R9 third is src5", msg_data, 32'h55);
      accept();
      chk("R9 drained", msg_valid, 0);

      // R10: generate word, guest forced to zero
      cfg_write(1'b1, 32'h0060_4000);
      gen_wr_en = 1'b1; gen_wr_data = 32'h000B_F0AB;
      @(negedge clk);
      gen_wr_en = 1'b0;
      chk("R10 stored copy", gen_o, 32'h0008_00AB);
      wait_msg(seen);
      chk("R10 addr", msg_addr, 64'h0000_0000_0008_0000);
      chk("R10 data", msg_data, 32'hAB);
      accept();

      // R11: generate word beats a source arriving together
      src_target[3*32 +: 32] = 32'h0000_0033;
      src_en[3] = 1'b1;
      gen_wr_en = 1'b1; gen_wr_data = 32'h0000_0077;
      src_pend_set = 8'b0000_1000;
      @(negedge clk);
      gen_wr_en = 1'b0; src_pend_set = '0;
      wait_msg(seen);
      chk("R11 generate first", msg_data, 32'h77);
      accept();
      chk("R11 source next", msg_data, 32'h33);
      accept();

      // R3: lock freezes both words
      cfg_write(1'b0, 32'h0000_ABCD);
      cfg_write(1'b1, 32'h8000_0123);
      lo_before = cfg_lo_o;
      cfg_write(1'b0, 32'hDEAD_0000);
      cfg_write(1'b1, 32'h0000_0000);
      chk("R3 lo frozen", cfg_lo_o, lo_before);
      chk("R3 hi frozen", cfg_hi_o, 32'h8000_0123);

      finish_run();
   end

endmodule